// File: doc/BRIEF.md
# Quad-Channel Serial DAC Register Interface

This block is the digital front end of a four-channel, 8-bit output converter. A host shifts a 12-bit word in on a serial data line, most significant bit first, one bit per rising edge of a serial clock. It then raises a load strobe. The 8-bit payload of the word goes into one of four channel holding registers. Those registers drive the converter codes. The analog stages are outside this block.

Each word carries a 2-bit device-select field. A load is accepted only when this field matches the two strap inputs. Several devices can therefore share one serial bus. The serial clock, serial data, strobe and forced-clear inputs all cross into the system clock domain through synchronizer chains. Edge detection on the synchronized serial clock and strobe turns each rising edge into a single event.

Two events clear all four codes to zero. The first is the synchronous power-on reset. The second is an active-low forced-clear input: the codes stay at zero for as long as it is held low.

Top module: `qdac_serial_front`

## Requirements
- R1: Word layout: 12 bits, sent most significant bit first. Bits [11:10] are the device-select field, bits [9:8] the channel number (0 to 3), and bits [7:0] the code. One bit is taken on each rising edge of `sclk_in`.
- R2: On a rising edge of `load_in`, when the word is accepted, the code is written into the register of the addressed channel.
- R3: A word whose bits [11:10] differ from `strap_sel[1:0]` changes none of the four registers.
- R4: An accepted load changes only the addressed channel. The other three keep their values.
- R5: A strobe held high causes exactly one write. Words shifted in while the strobe stays high are not written until the strobe rises again.
- R6: While `clr_n` is low, all four codes read 0x00 within 3 clock cycles. Loads made during that time are ignored.
- R7: After `rst`, all four codes are 0x00. When `clr_n` returns high, the codes stay at 0x00 until the next accepted load.
- R8: A write becomes visible on `ch_code_flat` no more than 4 system clock cycles after `load_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_n | input | 1 | Asynchronous active-low forced clear of all codes |
| sclk_in | input | 1 | Serial clock; a bit is taken on its rising edge |
| sdat_in | input | 1 | Serial data, MSB first |
| load_in | input | 1 | Load strobe; its rising edge commits the word |
| strap_sel | input | 2 | Device-select straps compared with word bits [11:10] |
| ch_code_flat | output | 32 | Four 8-bit codes; channel k is at bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: an 8-bit code, a 2-bit channel field, a 2-bit select field and two synchronizer stages. This matches the four-channel device and makes every select/strap combination reachable by random stimulus. The bench changes the strap value between batches so that matching and mismatching words both occur often. A held-strobe case and a clear-during-load case reach the edge-detection and clear-priority paths.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int DEF_CODE_W = 8;
  localparam int DEF_CH_W   = 2;
  localparam int DEF_CS_W   = 2;
  localparam int DEF_SYNC   = 2;

  typedef enum int {
    IDX_SCLK = 0,
    IDX_SDAT = 1,
    IDX_LOAD = 2,
    IDX_CLR  = 3
  } sync_idx_e;

  localparam int SYNC_BITS = 4;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk) begin
    if (rst)           frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
  end
endmodule

// File: rtl/qdac_latch_bank.sv
module qdac_latch_bank #(
  parameter int CODE_W = 8,
  parameter int CH_W   = 2,
  localparam int CH_N  = 1 << CH_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   wr_en,
  input  logic [CH_W-1:0]        wr_ch,
  input  logic [CODE_W-1:0]      wr_code,
  output logic [CH_N*CODE_W-1:0] codes
);
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [CODE_W-1:0] held;
    always_ff @(posedge clk) begin
      if (rst || clear)                      held <= '0;
      else if (wr_en && wr_ch == CH_W'(c))   held <= wr_code;
    end
    assign codes[c*CODE_W +: CODE_W] = held;
  end
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
  import qdac_pkg::*;
#(
  parameter int CODE_W      = DEF_CODE_W,
  parameter int CH_W        = DEF_CH_W,
  parameter int CS_W        = DEF_CS_W,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int CH_N       = 1 << CH_W,
  localparam int FRAME_W    = CS_W + CH_W + CODE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_n,
  input  logic                   sclk_in,
  input  logic                   sdat_in,
  input  logic                   load_in,
  input  logic [CS_W-1:0]        strap_sel,
  output logic [CH_N*CODE_W-1:0] ch_code_flat
);
  logic [SYNC_BITS-1:0] raw_in, synced;
  logic                 sclk_prev, load_prev;
  logic                 sclk_rise, load_rise;
  logic                 clr_ok;
  logic [FRAME_W-1:0]   frame;
  logic [CS_W-1:0]      frame_cs;
  logic [CH_W-1:0]      frame_ch;
  logic [CODE_W-1:0]    frame_code;
  logic                 wr_en;

  always_comb begin
    raw_in           = '0;
    raw_in[IDX_SCLK] = sclk_in;
    raw_in[IDX_SDAT] = sdat_in;
    raw_in[IDX_LOAD] = load_in;
    raw_in[IDX_CLR]  = clr_n;
  end

  qdac_sync #(.WIDTH(SYNC_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (raw_in), .q (synced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      load_prev <= 1'b0;
    end else begin
      sclk_prev <= synced[IDX_SCLK];
      load_prev <= synced[IDX_LOAD];
    end
  end

  assign sclk_rise = synced[IDX_SCLK] & ~sclk_prev;
  assign load_rise = synced[IDX_LOAD] & ~load_prev;
  assign clr_ok    = synced[IDX_CLR];

  qdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk (clk), .rst (rst), .shift_en (sclk_rise),
    .bit_in (synced[IDX_SDAT]), .frame (frame)
  );

  assign frame_cs   = frame[FRAME_W-1 -: CS_W];
  assign frame_ch   = frame[CODE_W +: CH_W];
  assign frame_code = frame[CODE_W-1:0];
  assign wr_en      = load_rise & clr_ok & (frame_cs == strap_sel);

  qdac_latch_bank #(.CODE_W(CODE_W), .CH_W(CH_W)) u_bank (
    .clk (clk), .rst (rst), .clear (~clr_ok), .wr_en (wr_en),
    .wr_ch (frame_ch), .wr_code (frame_code), .codes (ch_code_flat)
  );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int CODE_W = 8,
  parameter int CH_N   = 4,
  parameter int CS_W   = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr_n,
  input logic                   clr_ok,
  input logic                   wr_en,
  input logic [CS_W-1:0]        frame_cs,
  input logic [CS_W-1:0]        strap_sel,
  input logic [CH_N*CODE_W-1:0] ch_code_flat
);
  logic [CH_N*CODE_W-1:0] prev_codes;
  logic [CH_N-1:0]        chg;

  always_ff @(posedge clk) begin
    if (rst) prev_codes <= '0;
    else     prev_codes <= ch_code_flat;
  end

  always_comb begin
    for (int c = 0; c < CH_N; c++)
      chg[c] = ch_code_flat[c*CODE_W +: CODE_W] != prev_codes[c*CODE_W +: CODE_W];
  end

  p_reset_zero_r7: assert property (@(posedge clk)
    rst |=> ch_code_flat == '0);

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_n, 3) && !$past(clr_n, 2) && !$past(clr_n)) |-> ch_code_flat == '0);

  p_select_match_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> frame_cs == strap_sel);

  p_hold_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && $past(clr_ok)) |-> $stable(ch_code_flat));

  p_one_channel_r4: assert property (@(posedge clk) disable iff (rst)
    $past(clr_ok) |-> $countones(chg) <= 1);

  p_single_event_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

bind qdac_serial_front qdac_checker #(
  .CODE_W(CODE_W), .CH_N(CH_N), .CS_W(CS_W)
) u_chk (
  .clk (clk), .rst (rst), .clr_n (clr_n), .clr_ok (clr_ok),
  .wr_en (wr_en), .frame_cs (frame_cs), .strap_sel (strap_sel),
  .ch_code_flat (ch_code_flat)
);

// File: tb/sim_qdac_serial_front.sv
`timescale 1ns/1ps
module sim_qdac_serial_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_n = 1'b1;
  logic        sclk_in = 1'b0;
  logic        sdat_in = 1'b0;
  logic        load_in = 1'b0;
  logic [1:0]  strap_sel = 2'b00;
  logic [31:0] ch_code_flat;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [4];

  always #2.5 clk = ~clk;

  qdac_serial_front u0 (
    .clk (clk), .rst (rst), .clr_n (clr_n), .sclk_in (sclk_in),
    .sdat_in (sdat_in), .load_in (load_in), .strap_sel (strap_sel),
    .ch_code_flat (ch_code_flat)
  );

  function automatic logic [11:0] make_word(logic [1:0] cs, logic [1:0] ch, logic [7:0] code);
    return {cs, ch, code};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < 4; c++) begin
      checks++;
      if (ch_code_flat[c*8 +: 8] !== model[c]) begin
        errors++;
        $display("FAIL %s ch%0d: got %h expected %h", tag, c, ch_code_flat[c*8 +: 8], model[c]);
      end
    end
  endtask

  task automatic shift_word(logic [11:0] w);
    for (int i = 11; i >= 0; i--) begin
      sdat_in = w[i];
      wait_clk(4);
      sclk_in = 1'b1;
      wait_clk(4);
      sclk_in = 1'b0;
    end
    wait_clk(4);
  endtask

  task automatic pulse_load(int hold);
    load_in = 1'b1;
    wait_clk(hold);
    load_in = 1'b0;
    wait_clk(5);
  endtask

  task automatic send(logic [1:0] cs, logic [1:0] ch, logic [7:0] code);
    shift_word(make_word(cs, ch, code));
    pulse_load(6);
    if (cs == strap_sel && clr_n) model[ch] = code;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) model[c] = 8'h00;
    void'($urandom(32'h5eed_0042));
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    check_all("R7 reset");

    strap_sel = 2'b10;
    send(2'b10, 2'd0, 8'h81); check_all("R1 R2 ch0 msb-first");
    send(2'b10, 2'd3, 8'h3C); check_all("R2 R4 ch3");
    send(2'b10, 2'd1, 8'hA5); check_all("R4 ch1");
    send(2'b01, 2'd2, 8'hFF); check_all("R3 select mismatch");
    send(2'b00, 2'd0, 8'h11); check_all("R3 select mismatch 2");

    // R5: strobe held high while a new word is shifted in
    shift_word(make_word(2'b10, 2'd2, 8'h5A));
    load_in = 1'b1;
    wait_clk(6);
    model[2] = 8'h5A;
    shift_word(make_word(2'b10, 2'd2, 8'hC3));
    check_all("R5 held strobe first write");
    load_in = 1'b0;
    wait_clk(5);
    check_all("R5 no second write");
    pulse_load(6);
    model[2] = 8'hC3;
    check_all("R5 new rise writes");

    // R8: latency from strobe rise
    shift_word(make_word(2'b10, 2'd1, 8'h77));
    load_in = 1'b1;
    wait_clk(4);
    model[1] = 8'h77;
    check_all("R8 latency");
    load_in = 1'b0;
    wait_clk(5);

    // R6: forced clear, loads ignored while low
    clr_n = 1'b0;
    for (int c = 0; c < 4; c++) model[c] = 8'h00;
    wait_clk(3);
    check_all("R6 clear");
    send(2'b10, 2'd0, 8'hEE);
    check_all("R6 load ignored in clear");
    clr_n = 1'b1;
    wait_clk(5);
    check_all("R7 release keeps zero");

    // random batches with changing straps
    for (int b = 0; b < 4; b++) begin
      strap_sel = 2'($urandom);
      wait_clk(2);
      for (int k = 0; k < 30; k++) begin
        logic [1:0] cs;
        cs = ($urandom % 2 == 0) ? strap_sel : 2'($urandom);
        send(cs, 2'($urandom), 8'($urandom));
        check_all("R1 R2 R3 R4 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule